// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Model

This block behaves as a 512-byte serial EEPROM attached to an SPI bus. A master lowers the active-low chip select, clocks in a one-byte instruction MSB first on `sdi`, and then an address or data bytes as the instruction needs. Read data and status come back on `sdo`. The ninth address bit does not travel in the address byte. It is carried in bit 3 of the read and write instruction bytes, which splits the array into a lower and an upper 256-byte half.

Writes are held back by a write-enable latch. A page write gathers up to 16 bytes and stores them only when chip select rises after a whole number of bytes. A write-in-progress flag then stays set for a programmable number of system clocks, and the master polls it through the status register. Two block-protect bits can lock the top quarter, the top half or the whole array. All bus pins are resynchronised to the system clock, so the bus clock must run well below the system clock. Bus modes (CPOL,CPHA) = (0,0) and (1,1) both work: input bits are captured on SCK rising edges and output bits change on SCK falling edges.

Top module: `ee_spi_slave`

## Requirements
- R1: After reset `sdo` is 0, the status byte reads 0x00 and every memory byte reads 0xFF.
- R2: Both bus modes (0,0) and (1,1) work. `sdi` is captured on the SCK rising edge and `sdo` changes on the SCK falling edge, MSB first. `sdo` is 0 while chip select is high.
- R3: Instruction 0x06 sets the write-enable latch and 0x04 clears it. Either one takes effect at the chip-select rise only when exactly 8 bits were sent.
- R4: Instruction 0x05 returns the status byte {4'b0, BP1, BP0, WEL, WIP} with WIP at bit 0, WEL at bit 1, BP0 at bit 2 and BP1 at bit 3. The byte is resent for every further byte clocked.
- R5: Instruction 0000_A011 is a read. A is address bit 8 and the next byte holds address bits 7:0. Data bytes follow from that address, incrementing, and wrap from 0x1FF to 0x000. Bits on `sdi` during data bytes are ignored.
- R6: Instruction 0000_A010 followed by the address and 1 or more data bytes writes those bytes when chip select rises. Successive bytes wrap inside the aligned 16-byte page, and a later byte overwrites an earlier byte that lands on the same location.
- R7: A write or status write sent while the write-enable latch is clear is ignored. WIP stays 0 and memory and status are unchanged.
- R8: A committed write sets WIP for BUSY_CYCLES system clocks. When the busy time ends, WIP and WEL both clear.
- R9: While WIP is set, every instruction except status read is ignored. A read during this time returns 0x00 bytes.
- R10: Instruction 0x01 followed by a byte loads bits 3:2 of that byte into BP1:BP0 and ignores the other bits. It needs WEL and starts the busy period.
- R11: BP=01 locks 0x180–0x1FF, BP=10 locks 0x100–0x1FF and BP=11 locks the whole array. A write into a locked page is ignored completely: no busy period, and WEL stays set.
- R12: A write frame that ends part-way through a byte is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial bus clock from the master |
| sdi | input | 1 | Serial data into the slave |
| sdo | output | 1 | Serial data out of the slave |

## Verification
The assertions assume that every SCK edge and chip-select edge is separated from the next by more than the synchroniser depth plus one system clock. They also assume that `sdi` settles before the rising SCK edge that captures it. The stimulus holds each SCK phase for 8 system clocks and puts 8 clocks between chip-select edges and the nearest SCK edge. Between transactions the stimulus waits longer than the busy time, except where it deliberately issues instructions while a write is still in progress.

// File: rtl/ee_spi_pkg.sv
package ee_spi_pkg;

  typedef enum logic [2:0] {
    OP_NONE, OP_SETWEL, OP_CLRWEL, OP_RDSTAT, OP_WRSTAT, OP_READ, OP_WRITE
  } ee_op_e;

  // status bit positions
  localparam int ST_WIP = 0;
  localparam int ST_WEL = 1;
  localparam int ST_BP0 = 2;
  localparam int ST_BP1 = 3;

  // instruction decode; only the status read is accepted while busy
  function automatic ee_op_e decode_op(input logic [7:0] b, input logic busy);
    ee_op_e op;
    op = OP_NONE;
    if (b == 8'h05)                           op = OP_RDSTAT;
    else if (b == 8'h06)                      op = OP_SETWEL;
    else if (b == 8'h04)                      op = OP_CLRWEL;
    else if (b == 8'h01)                      op = OP_WRSTAT;
    else if (b[7:4] == 4'h0 && b[2:0] == 3'b011) op = OP_READ;
    else if (b[7:4] == 4'h0 && b[2:0] == 3'b010) op = OP_WRITE;
    if (busy && op != OP_RDSTAT) op = OP_NONE;
    return op;
  endfunction

  // protection by the two top address bits
  function automatic logic region_locked(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] status_byte(input logic [1:0] bp, input logic wel,
                                             input logic wip);
    logic [7:0] s;
    s = 8'h00;
    s[ST_WIP] = wip;
    s[ST_WEL] = wel;
    s[ST_BP0] = bp[0];
    s[ST_BP1] = bp[1];
    return s;
  endfunction

endpackage

// File: rtl/ee_spi_sync.sv
module ee_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  output logic cs_act,
  output logic cs_end,
  output logic sck_rise,
  output logic sck_fall,
  output logic sdi_s
);
  logic [STAGES-1:0] cs_pipe, sck_pipe, sdi_pipe;
  logic cs_prev, sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe  <= '1;
      sck_pipe <= '0;
      sdi_pipe <= '0;
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      cs_pipe  <= {cs_pipe[STAGES-2:0], cs_n};
      sck_pipe <= {sck_pipe[STAGES-2:0], sck};
      sdi_pipe <= {sdi_pipe[STAGES-2:0], sdi};
      cs_prev  <= cs_pipe[STAGES-1];
      sck_prev <= sck_pipe[STAGES-1];
    end
  end

  assign cs_act   = !cs_pipe[STAGES-1];
  assign cs_end   = cs_pipe[STAGES-1] && !cs_prev;
  assign sck_rise = cs_act && sck_pipe[STAGES-1] && !sck_prev;
  assign sck_fall = cs_act && !sck_pipe[STAGES-1] && sck_prev;
  assign sdi_s    = sdi_pipe[STAGES-1];
endmodule

// File: rtl/ee_busy_timer.sv
module ee_busy_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= CW'(CYCLES);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = cnt_q != '0;
  assign done = cnt_q == CW'(1) && !start;
endmodule

// File: rtl/ee_mem_array.sv
module ee_mem_array #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [7:0]                   rd_data,
  input  logic                         we,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page,
  input  logic [PAGE_BYTES-1:0][7:0]   lane_data,
  input  logic [PAGE_BYTES-1:0]        lane_vld
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = $clog2(PAGE_BYTES);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we) begin
      for (int l = 0; l < PAGE_BYTES; l++)
        if (lane_vld[l]) mem_q[{page, LANE_W'(l)}] <= lane_data[l];
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/ee_spi_slave.sv
module ee_spi_slave
  import ee_spi_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  output logic sdo
);
  localparam int LANE_W = $clog2(PAGE_BYTES);
  localparam int CNT_W  = 5;

  logic cs_act, cs_end, sck_rise, sck_fall, sdi_s;
  logic wip, busy_done, busy_start;
  logic wr_commit, sr_commit, wel_set, wel_clr, mem_we;

  ee_op_e                  op_q;
  logic                    a8_q;
  logic [6:0]              sh_q;
  logic [2:0]              bit_q;
  logic [CNT_W-1:0]        nbyte_q;
  logic [7:0]              tx_q;
  logic                    sdo_q;
  logic [ADDR_W-1:0]       rd_ptr_q, wr_base_q;
  logic [LANE_W-1:0]       lane_q;
  logic [PAGE_BYTES-1:0][7:0] buf_q;
  logic [PAGE_BYTES-1:0]   vld_q;
  logic [1:0]              sr_bp_q;
  logic                    wel;
  logic [1:0]              bp;

  logic [7:0]        byte_v, mem_rd, status;
  logic [ADDR_W-1:0] addr_v, rd_addr;
  logic              byte_done, whole;
  ee_op_e            op_dec;

  ee_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .cs_act(cs_act), .cs_end(cs_end), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sdi_s(sdi_s)
  );

  ee_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(busy_start), .busy(wip), .done(busy_done)
  );

  ee_mem_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_mem (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(mem_rd),
    .we(mem_we), .page(wr_base_q[ADDR_W-1:LANE_W]), .lane_data(buf_q), .lane_vld(vld_q)
  );

  // byte assembly and decode helpers
  assign byte_v    = {sh_q, sdi_s};
  assign byte_done = sck_rise && bit_q == 3'd7;
  assign whole     = bit_q == 3'd0;
  assign addr_v    = ADDR_W'({a8_q, byte_v});
  assign rd_addr   = (nbyte_q == CNT_W'(1)) ? addr_v : rd_ptr_q;
  assign op_dec    = decode_op(byte_v, wip);
  assign status    = status_byte(bp, wel, wip);

  // frame-end events
  assign wr_commit = cs_end && op_q == OP_WRITE && whole && nbyte_q >= CNT_W'(3) &&
                     wel && !wip && !region_locked(bp, wr_base_q[ADDR_W-1 -: 2]);
  assign sr_commit = cs_end && op_q == OP_WRSTAT && whole && nbyte_q >= CNT_W'(2) &&
                     wel && !wip;
  assign wel_set   = cs_end && op_q == OP_SETWEL && whole && nbyte_q == CNT_W'(1);
  assign wel_clr   = cs_end && op_q == OP_CLRWEL && whole && nbyte_q == CNT_W'(1);
  assign mem_we    = wr_commit;
  assign busy_start = wr_commit || sr_commit;

  // serial receive and command state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_NONE; a8_q <= 1'b0; sh_q <= '0; bit_q <= '0; nbyte_q <= '0;
      tx_q <= '0; rd_ptr_q <= '0; wr_base_q <= '0; lane_q <= '0;
      buf_q <= '0; vld_q <= '0; sr_bp_q <= '0;
    end else if (!cs_act) begin
      op_q <= cs_end ? op_q : OP_NONE;
      bit_q <= cs_end ? bit_q : 3'd0;
      nbyte_q <= cs_end ? nbyte_q : '0;
      vld_q <= cs_end ? vld_q : '0;
      tx_q <= '0;
    end else if (sck_rise) begin
      sh_q  <= byte_v[6:0];
      bit_q <= bit_q + 1'b1;
      if (byte_done) begin
        if (nbyte_q != '1) nbyte_q <= nbyte_q + 1'b1;
        tx_q <= '0;
        if (nbyte_q == '0) begin
          op_q <= op_dec;
          a8_q <= byte_v[3];
          if (op_dec == OP_RDSTAT) tx_q <= status;
        end else if (nbyte_q == CNT_W'(1)) begin
          rd_ptr_q  <= addr_v + 1'b1;
          wr_base_q <= addr_v;
          lane_q    <= addr_v[LANE_W-1:0];
          sr_bp_q   <= byte_v[ST_BP1:ST_BP0];
          if (op_q == OP_READ)   tx_q <= mem_rd;
          if (op_q == OP_RDSTAT) tx_q <= status;
        end else begin
          case (op_q)
            OP_READ: begin
              tx_q     <= mem_rd;
              rd_ptr_q <= rd_ptr_q + 1'b1;
            end
            OP_WRITE: begin
              buf_q[lane_q] <= byte_v;
              vld_q[lane_q] <= 1'b1;
              lane_q        <= lane_q + 1'b1;
            end
            OP_RDSTAT: tx_q <= status;
            default: ;
          endcase
        end
      end
    end
  end

  // serial transmit: next bit on each falling bus clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sdo_q <= 1'b0;
    else if (!cs_act)  sdo_q <= 1'b0;
    else if (sck_fall) sdo_q <= tx_q[3'd7 - bit_q];
  end
  assign sdo = sdo_q;

  // status register state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
      bp  <= 2'b00;
    end else begin
      if (sr_commit) bp <= sr_bp_q;
      if (busy_done || wel_clr) wel <= 1'b0;
      else if (wel_set)         wel <= 1'b1;
    end
  end
endmodule

// File: rtl/ee_spi_slave_chk.sv
module ee_spi_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_act,
  input logic       cs_end,
  input logic       sdo,
  input logic       wip,
  input logic       wel,
  input logic [1:0] bp,
  input logic       mem_we,
  input logic       busy_start,
  input logic       busy_done
);
  p_wip_after_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cs_end));

  p_commit_needs_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_start |-> wel);

  p_wel_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_done |=> !wel);

  p_bp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_start |=> $stable(bp));

  p_quiet_sdo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && $past(!cs_act)) |-> !sdo);

  p_write_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> wip);

  p_no_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_start |-> !wip);
endmodule

bind ee_spi_slave ee_spi_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_end(cs_end), .sdo(sdo),
  .wip(wip), .wel(wel), .bp(bp), .mem_we(mem_we), .busy_start(busy_start),
  .busy_done(busy_done)
);

// File: tb/ee_spi_slave_tb.sv
module ee_spi_slave_tb;
  localparam int BUSY = 1000;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo;
  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model state
  byte unsigned mem_m [512];
  bit wel_m = 0, busy_m = 0;
  bit [1:0] bp_m = 0;
  byte unsigned txq [$];

  always #4 clk = ~clk;

  ee_spi_slave #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .sdo(sdo)
  );

  // per-clock comparison: idle bus must give a low output
  int idle_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && cs_n) idle_cnt++; else idle_cnt = 0;
    if (idle_cnt > 4 && sdo !== 1'b0 && !finished) begin
      fails++;
      $display("FAIL R2 idle output got %b exp 0", sdo);
    end
  end

  function automatic byte unsigned stat_m();
    return {4'b0, bp_m, wel_m, busy_m};
  endfunction

  function automatic bit locked_m(int a);
    case (bp_m)
      2'd1: return a >= 384;
      2'd2: return a >= 256;
      2'd3: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // one bus transaction; expected bytes come from the model before its effects apply
  task automatic frame(input bit m3, input int nbits, input string tag);
    byte unsigned rx [$];
    byte unsigned cur = 0;
    int nby = nbits / 8;
    byte unsigned op = txq[0];
    int addr = (int'(op[3]) << 8) | int'(txq.size() > 1 ? txq[1] : 0);
    sck = m3; sdi = 0;
    repeat (HALF) @(negedge clk);
    cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sck = 0;
      sdi = txq[i / 8][7 - (i % 8)];
      repeat (HALF) @(negedge clk);
      cur = {cur[6:0], sdo};
      sck = 1;
      repeat (HALF) @(negedge clk);
      if (i % 8 == 7) rx.push_back(cur);
    end
    if (!m3) sck = 0;
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (2 * HALF) @(negedge clk);
    for (int j = 0; j < nby; j++) begin
      byte unsigned e = 0;
      if (op == 8'h05 && j >= 1) e = stat_m();
      else if (!busy_m && op[7:4] == 0 && op[2:0] == 3'b011 && j >= 2)
        e = mem_m[(addr + j - 2) % 512];
      check(rx[j] == e, $sformatf("%s byte %0d", tag, j), rx[j], e);
    end
    if (!busy_m) begin
      if (op == 8'h06 && nbits == 8) wel_m = 1;
      if (op == 8'h04 && nbits == 8) wel_m = 0;
      if (op == 8'h01 && nbits % 8 == 0 && nby >= 2 && wel_m) begin
        bp_m = txq[1][3:2]; busy_m = 1;
      end
      if (op[7:4] == 0 && op[2:0] == 3'b010 && nbits % 8 == 0 && nby >= 3 && wel_m &&
          !locked_m(addr)) begin
        for (int k = 2; k < nby; k++)
          mem_m[(addr & 9'h1F0) | ((addr + k - 2) & 15)] = txq[k];
        busy_m = 1;
      end
    end
    txq.delete();
  endtask

  task automatic wait_idle();
    repeat (BUSY + 100) @(negedge clk);
    if (busy_m) begin busy_m = 0; wel_m = 0; end
  endtask

  task automatic rdsr(input bit m3, input string tag);
    txq = '{8'h05, 8'h00, 8'h00};
    frame(m3, 24, tag);
  endtask

  task automatic rd(input bit m3, input int a, input int n, input string tag);
    txq.push_back(8'h03 | ((a >> 5) & 8'h08));
    txq.push_back(a & 8'hFF);
    for (int k = 0; k < n; k++) txq.push_back(8'hA5);
    frame(m3, 8 * (n + 2), tag);
  endtask

  task automatic wr(input bit m3, input int a, input int n, input int seed, input int extra,
                    input string tag);
    txq.push_back(8'h02 | ((a >> 5) & 8'h08));
    txq.push_back(a & 8'hFF);
    for (int k = 0; k < n; k++) txq.push_back((seed + 7 * k) & 8'hFF);
    if (extra > 0) txq.push_back(8'h5A);
    frame(m3, 8 * (n + 2) + extra, tag);
  endtask

  task automatic cmd1(input bit m3, input byte unsigned b, input string tag);
    txq.push_back(b);
    frame(m3, 8, tag);
  endtask

  task automatic wrsr(input bit m3, input byte unsigned v, input string tag);
    txq = '{8'h01, v};
    frame(m3, 16, tag);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem_m[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(sdo == 1'b0, "R1 reset output", sdo, 0);
    rdsr(0, "R1 R4 reset status");
    rd(0, 9'h000, 3, "R1 R5 erased read");

    // R7: write without the latch is dropped
    wr(0, 9'h010, 4, 8'h11, 0, "R7 write no latch");
    rdsr(0, "R7 status after ignored write");
    rd(1, 9'h010, 4, "R7 memory unchanged");

    // R3: latch set and cleared; a 9-bit frame has no effect
    cmd1(0, 8'h06, "R3 set latch");
    rdsr(1, "R3 status latch set");
    cmd1(1, 8'h04, "R3 clear latch");
    rdsr(0, "R3 status latch clear");
    txq = '{8'h06, 8'h00};
    frame(0, 9, "R3 nine-bit frame");
    rdsr(0, "R3 latch unchanged by partial frame");

    // R6 R8 R9: page write in the upper half, wrap inside page
    cmd1(0, 8'h06, "R6 latch");
    wr(0, 9'h1F4, 16, 8'h30, 0, "R6 page write upper half");
    rdsr(0, "R8 busy visible");
    rd(0, 9'h1F0, 2, "R9 read while busy returns zero");
    wrsr(1, 8'h0C, "R9 status write while busy");
    wait_idle();
    rdsr(1, "R8 busy and latch cleared");
    rd(1, 9'h1EE, 20, "R5 R2 read wraps page and array mode3");

    // R6: 20 bytes overwrite the first lanes
    cmd1(1, 8'h06, "R6 latch");
    wr(1, 9'h020, 20, 8'h80, 0, "R6 overlong write mode3");
    wait_idle();
    rd(0, 9'h020, 16, "R6 overwrite readback");

    // R12: partial byte at the end discards the write
    cmd1(0, 8'h06, "R12 latch");
    wr(0, 9'h040, 2, 8'h22, 3, "R12 partial write");
    rdsr(0, "R12 status latch kept no busy");
    rd(0, 9'h040, 2, "R12 memory unchanged");

    // R10 R11: protect upper half, junk bits ignored
    wrsr(0, 8'hF8, "R10 status write");
    rdsr(0, "R10 busy after status write");
    wait_idle();
    rdsr(0, "R10 protect bits loaded");
    cmd1(0, 8'h06, "R11 latch");
    wr(0, 9'h150, 3, 8'h44, 0, "R11 locked write");
    rdsr(0, "R11 no busy latch kept");
    rd(0, 9'h150, 3, "R11 locked memory unchanged");
    wr(0, 9'h050, 3, 8'h55, 0, "R11 unlocked write");
    wait_idle();
    rd(1, 9'h050, 3, "R11 unlocked readback");
    wrsr(0, 8'h04, "R7 status write without latch");
    rdsr(0, "R7 protect bits kept");
    cmd1(0, 8'h06, "R11 latch");
    wrsr(0, 8'h04, "R11 quarter protect");
    wait_idle();
    cmd1(0, 8'h06, "R11 latch");
    wr(1, 9'h17F, 1, 8'h66, 0, "R11 below locked quarter");
    wait_idle();
    cmd1(0, 8'h06, "R11 latch");
    wr(1, 9'h180, 1, 8'h77, 0, "R11 locked quarter");
    rd(0, 9'h17F, 2, "R11 quarter readback");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule